// File: doc/BRIEF.md
# Local Memory Read Source Selector

This block sits beside a processor core that probes its tightly coupled SRAM, its ROM and its instruction cache in the same cycle for every read. Each of the two mapped memories owns a programmable window: a base address, a power-of-two size and an enable bit. The block compares the read address against both windows. It takes the cache's hit flag and the three candidate data words presented in that same cycle. It then settles on exactly one source: the SRAM window first, the ROM window second, the cache third, and an external bus cycle when nothing answers.

The array enables are combinational, so an array whose window is disabled or does not match is never strobed. The result is registered and appears on the response pins one clock after the address cycle. With the result comes a flag telling the cache not to allocate the line, raised whenever a mapped memory supplied the data. A single write port loads either window's base register.

The read side is a plain valid-qualified stream with no ready signal. The block accepts a request on every cycle that `req_valid` is high and produces its response exactly one cycle later. It never applies back-pressure. A consumer that cannot accept a response on that cycle must stall the core upstream.

Top module: `lmem_src_sel`

## Requirements
- R1: After reset both windows are disabled, all response outputs are 0, and a read is answered by the cache on a cache hit or by an external request otherwise.
- R2: When the address falls in the enabled SRAM window, the response source is SRAM (`resp_src` bit 0), and `resp_data` carries `sram_rdata` from the address cycle, whatever the ROM and cache report.
- R3: When the SRAM window misses and the enabled ROM window matches, the source is ROM (`resp_src` bit 1), and `resp_data` carries `rom_rdata`, whatever the cache reports.
- R4: When both windows miss and `cache_hit` is high, the source is the cache (`resp_src` bit 2), and `resp_data` carries `cache_rdata`.
- R5: When both windows and the cache miss, the source is external (`resp_src` bit 3), `ext_req` pulses for that one response cycle, and `resp_data` is 0.
- R6: `resp_no_alloc` is high exactly on responses whose source is SRAM or ROM.
- R7: A window matches when its enable bit is set and the address agrees with the base on every bit at or above position L. L is the size code, raised to MIN_LOG2 (default 9) when it is smaller, and when L is 32 or more every address matches.
- R8: A disabled window never matches, and its array enable stays low.
- R9: `sram_en` and `rom_en` are high in a cycle exactly when `req_valid` is high and the address matches that window. Both may be high together.
- R10: A write with `cfg_we` high loads the window chosen by `cfg_sel` (0 = SRAM, 1 = ROM) with base, size code and enable at the clock edge. A read in the same cycle is decided with the previous settings.
- R11: The response appears exactly one cycle after the address cycle. A cycle without `req_valid` yields `resp_valid`, `resp_src`, `ext_req` and `resp_no_alloc` all low the next cycle.
- R12: While `resp_valid` is high, exactly one bit of `resp_src` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Base register write strobe |
| cfg_sel | input | 1 | Window written: 0 SRAM, 1 ROM |
| cfg_base | input | 32 | Window base address |
| cfg_log2 | input | 5 | Window size as log2 of bytes |
| cfg_valid | input | 1 | Window enable bit |
| req_valid | input | 1 | Read address cycle qualifier |
| req_addr | input | 32 | Read address |
| sram_en | output | 1 | SRAM array enable (combinational) |
| rom_en | output | 1 | ROM array enable (combinational) |
| sram_rdata | input | 32 | SRAM candidate data, address cycle |
| rom_rdata | input | 32 | ROM candidate data, address cycle |
| cache_hit | input | 1 | Cache hit flag, address cycle |
| cache_rdata | input | 32 | Cache candidate data, address cycle |
| resp_valid | output | 1 | Response valid, one cycle after request |
| resp_src | output | 4 | One-hot source: bit0 SRAM, bit1 ROM, bit2 cache, bit3 external |
| resp_data | output | 32 | Selected read data |
| resp_no_alloc | output | 1 | Cache allocation inhibit |
| ext_req | output | 1 | External bus cycle request strobe |

## Verification
A base register write and a read can land in the same cycle. The bench provokes this by enabling or moving a window with an address inside its new range presented on that very cycle. The response must follow the old window, and the next read must follow the new one. Two hit sources can also coincide: both windows may be programmed to overlap while `cache_hit` is high, and the reference model checks that the higher-priority source alone wins and that allocation is inhibited. Long random runs mix reprogramming, overlapping windows and cache hits, and the model judges every cycle's enables and responses.

// File: rtl/lmsel_pkg.sv
package lmsel_pkg;
  localparam int NUM_SRC = 4;
  localparam int NUM_WIN = 2;

  typedef enum logic [1:0] {
    SRC_SRAM  = 2'd0,
    SRC_ROM   = 2'd1,
    SRC_CACHE = 2'd2,
    SRC_EXT   = 2'd3
  } src_e;

  localparam logic WIN_SRAM = 1'b0;
  localparam logic WIN_ROM  = 1'b1;
endpackage

// File: rtl/lmsel_region_reg.sv
module lmsel_region_reg #(
  parameter int ADDR_W   = 32,
  parameter int LOG2_W   = 5,
  parameter int MIN_LOG2 = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [LOG2_W-1:0] wr_log2,
  input  logic              wr_valid,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] mask_q,
  output logic              valid_q
);
  localparam logic [LOG2_W-1:0] FLOOR = LOG2_W'(MIN_LOG2);

  logic [LOG2_W-1:0] lg_q;
  logic [LOG2_W-1:0] lg_clamped;

  assign lg_clamped = (wr_log2 < FLOOR) ? FLOOR : wr_log2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      lg_q    <= FLOOR;
      valid_q <= 1'b0;
    end else if (wr_en) begin
      base_q  <= wr_base;
      lg_q    <= lg_clamped;
      valid_q <= wr_valid;
    end
  end

  always_comb begin
    for (int i = 0; i < ADDR_W; i++) begin
      mask_q[i] = (i >= int'(lg_q));
    end
  end

  p_write_lands_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (valid_q == $past(wr_valid)) && (base_q == $past(wr_base)));

  p_mask_floor_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    mask_q[MIN_LOG2-1:0] == '0);
endmodule

// File: rtl/lmsel_region_match.sv
module lmsel_region_match #(
  parameter int ADDR_W = 32
) (
  input  logic              probe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] mask,
  input  logic              valid,
  output logic              hit,
  output logic              en
);
  logic [ADDR_W-1:0] diff;

  assign diff = (addr ^ base) & mask;
  assign hit  = valid && (diff == '0);
  assign en   = probe && hit;

  always_comb begin
    if (!valid) p_off_quiet_r8 : assert (!en);
  end
endmodule

// File: rtl/lmsel_pick.sv
module lmsel_pick
  import lmsel_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               sram_hit,
  input  logic               rom_hit,
  input  logic               cache_hit,
  input  logic [DATA_W-1:0]  sram_rdata,
  input  logic [DATA_W-1:0]  rom_rdata,
  input  logic [DATA_W-1:0]  cache_rdata,
  output logic               resp_valid,
  output logic [NUM_SRC-1:0] resp_src,
  output logic [DATA_W-1:0]  resp_data,
  output logic               resp_no_alloc,
  output logic               ext_req
);
  src_e              win;
  logic [NUM_SRC-1:0] win_oh;
  logic [DATA_W-1:0]  win_data;

  always_comb begin
    if (sram_hit)       win = SRC_SRAM;
    else if (rom_hit)   win = SRC_ROM;
    else if (cache_hit) win = SRC_CACHE;
    else                win = SRC_EXT;
  end

  always_comb begin
    win_oh = '0;
    win_oh[win] = 1'b1;
    unique case (win)
      SRC_SRAM:  win_data = sram_rdata;
      SRC_ROM:   win_data = rom_rdata;
      SRC_CACHE: win_data = cache_rdata;
      default:   win_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid    <= 1'b0;
      resp_src      <= '0;
      resp_data     <= '0;
      resp_no_alloc <= 1'b0;
      ext_req       <= 1'b0;
    end else if (req_valid) begin
      resp_valid    <= 1'b1;
      resp_src      <= win_oh;
      resp_data     <= win_data;
      resp_no_alloc <= (win == SRC_SRAM) || (win == SRC_ROM);
      ext_req       <= (win == SRC_EXT);
    end else begin
      resp_valid    <= 1'b0;
      resp_src      <= '0;
      resp_data     <= '0;
      resp_no_alloc <= 1'b0;
      ext_req       <= 1'b0;
    end
  end

  p_single_src_r12 : assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ($countones(resp_src) == 1));

  p_idle_gap_r11 : assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!resp_valid && !ext_req && !resp_no_alloc));

  p_sram_first_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sram_hit) |=> (resp_src[0] && resp_data == $past(sram_rdata)));

  p_rom_second_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !sram_hit && rom_hit) |=> (resp_src[1] && resp_data == $past(rom_rdata)));

  p_ext_strobe_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> (resp_valid && resp_src[3] && !resp_no_alloc));

  p_no_alloc_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_no_alloc == (resp_src[0] || resp_src[1])));
endmodule

// File: rtl/lmem_src_sel.sv
module lmem_src_sel
  import lmsel_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int LOG2_W   = 5,
  parameter int MIN_LOG2 = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [LOG2_W-1:0] cfg_log2,
  input  logic              cfg_valid,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              sram_en,
  output logic              rom_en,
  input  logic [DATA_W-1:0] sram_rdata,
  input  logic [DATA_W-1:0] rom_rdata,
  input  logic              cache_hit,
  input  logic [DATA_W-1:0] cache_rdata,
  output logic              resp_valid,
  output logic [3:0]        resp_src,
  output logic [DATA_W-1:0] resp_data,
  output logic              resp_no_alloc,
  output logic              ext_req
);
  logic [ADDR_W-1:0] w_base  [NUM_WIN];
  logic [ADDR_W-1:0] w_mask  [NUM_WIN];
  logic              w_valid [NUM_WIN];
  logic              w_hit   [NUM_WIN];
  logic              w_en    [NUM_WIN];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    logic sel_me;
    assign sel_me = cfg_we && (cfg_sel == 1'(g));

    lmsel_region_reg #(
      .ADDR_W  (ADDR_W),
      .LOG2_W  (LOG2_W),
      .MIN_LOG2(MIN_LOG2)
    ) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (sel_me),
      .wr_base (cfg_base),
      .wr_log2 (cfg_log2),
      .wr_valid(cfg_valid),
      .base_q  (w_base[g]),
      .mask_q  (w_mask[g]),
      .valid_q (w_valid[g])
    );

    lmsel_region_match #(
      .ADDR_W(ADDR_W)
    ) u_match (
      .probe(req_valid),
      .addr (req_addr),
      .base (w_base[g]),
      .mask (w_mask[g]),
      .valid(w_valid[g]),
      .hit  (w_hit[g]),
      .en   (w_en[g])
    );
  end

  assign sram_en = w_en[WIN_SRAM];
  assign rom_en  = w_en[WIN_ROM];

  lmsel_pick #(
    .DATA_W(DATA_W)
  ) u_pick (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .sram_hit     (w_hit[WIN_SRAM]),
    .rom_hit      (w_hit[WIN_ROM]),
    .cache_hit    (cache_hit),
    .sram_rdata   (sram_rdata),
    .rom_rdata    (rom_rdata),
    .cache_rdata  (cache_rdata),
    .resp_valid   (resp_valid),
    .resp_src     (resp_src),
    .resp_data    (resp_data),
    .resp_no_alloc(resp_no_alloc),
    .ext_req      (ext_req)
  );

  p_enable_needs_req_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    (sram_en || rom_en) |-> req_valid);

  p_reset_closed_r1 : assert property (@(posedge clk)
    !rst_n |=> (!w_valid[0] && !w_valid[1] && !resp_valid));
endmodule

// File: tb/lmem_src_sel_test.sv
module lmem_src_sel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [4:0]  cfg_log2 = '0;
  logic        cfg_valid = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        sram_en, rom_en;
  logic [31:0] sram_rdata = '0, rom_rdata = '0, cache_rdata = '0;
  logic        cache_hit = 1'b0;
  logic        resp_valid;
  logic [3:0]  resp_src;
  logic [31:0] resp_data;
  logic        resp_no_alloc, ext_req;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_base [2];
  int          m_lg   [2];
  bit          m_val  [2];
  bit          e_valid;
  logic [3:0]  e_src;
  logic [31:0] e_data;
  bit          e_na, e_ext;

  always #4 clk = ~clk;

  lmem_src_sel uut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_hit(int r, logic [31:0] a);
    if (!m_val[r]) return 0;
    if (m_lg[r] >= 32) return 1;
    return (a >> m_lg[r]) == (m_base[r] >> m_lg[r]);
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // one clock of stimulus: drive at negedge, check enables, model at posedge, compare at next negedge
  task automatic step(bit we, bit sel, logic [31:0] base, int lg, bit val,
                      bit rv, logic [31:0] addr, bit ch,
                      logic [31:0] sd, logic [31:0] rd, logic [31:0] cd);
    bit hs, hr;
    cfg_we = we; cfg_sel = sel; cfg_base = base; cfg_log2 = 5'(lg); cfg_valid = val;
    req_valid = rv; req_addr = addr; cache_hit = ch;
    sram_rdata = sd; rom_rdata = rd; cache_rdata = cd;
    #1;
    hs = m_hit(0, addr);
    hr = m_hit(1, addr);
    chk("R9 sram_en", 32'(sram_en), 32'(rv && hs));   // R8 also: disabled window keeps it low
    chk("R9 rom_en", 32'(rom_en), 32'(rv && hr));
    @(posedge clk);
    e_valid = rv;
    e_src = '0; e_data = '0; e_na = 0; e_ext = 0;
    if (rv) begin
      if (hs)      begin e_src = 4'b0001; e_data = sd; e_na = 1; end
      else if (hr) begin e_src = 4'b0010; e_data = rd; e_na = 1; end
      else if (ch) begin e_src = 4'b0100; e_data = cd; end
      else         begin e_src = 4'b1000; e_ext = 1; end
    end
    if (we) begin   // R10: takes effect after this read was decided
      m_base[sel] = base;
      m_lg[sel]   = (lg < 9) ? 9 : lg;
      m_val[sel]  = val;
    end
    @(negedge clk);
    chk("R11 resp_valid", 32'(resp_valid), 32'(e_valid));
    chk("R2/R3/R4/R5/R12 resp_src", 32'(resp_src), 32'(e_src));
    chk("R2/R3/R4/R5 resp_data", resp_data, e_data);
    chk("R6 resp_no_alloc", 32'(resp_no_alloc), 32'(e_na));
    chk("R5 ext_req", 32'(ext_req), 32'(e_ext));
  endtask

  task automatic rd(logic [31:0] a, bit ch);
    step(0, 0, 0, 0, 0, 1, a, ch, $urandom, $urandom, $urandom);
  endtask

  task automatic wr(bit sel, logic [31:0] base, int lg, bit val);
    step(1, sel, base, lg, val, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 2; r++) begin m_base[r] = 0; m_lg[r] = 9; m_val[r] = 0; end
    req_valid = 1'b1;
    req_addr = 32'h0000_0000;
    repeat (3) @(negedge clk);
    // R1: outputs zero in reset, enables low since windows closed
    chk("R1 resp_valid reset", 32'(resp_valid), 0);
    chk("R1 resp_src reset", 32'(resp_src), 0);
    chk("R1 ext_req reset", 32'(ext_req), 0);
    chk("R1 sram_en reset", 32'(sram_en), 0);
    req_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    // R1: after reset reads go to cache or external
    rd(32'h0000_0000, 1);
    rd(32'h2000_0010, 0);
    step(0, 0, 0, 0, 0, 0, 32'h2000_0010, 1, 1, 2, 3);   // R11 idle cycle
    // program SRAM 4 KiB at 0x2000_0000, ROM 64 KiB at 0
    wr(0, 32'h2000_0000, 12, 1);
    wr(1, 32'h0000_0000, 16, 1);
    rd(32'h2000_0FFC, 1);   // R2 SRAM beats cache
    rd(32'h2000_1000, 0);   // R5 just past SRAM
    rd(32'h0000_FFFC, 1);   // R3 ROM beats cache
    rd(32'h0001_0000, 1);   // R4 cache
    rd(32'h0001_0000, 0);   // R5 external
    // overlap: ROM covers whole 0x2000_0000 64 KiB, SRAM still wins (R2)
    wr(1, 32'h2000_0000, 16, 1);
    rd(32'h2000_0004, 1);
    rd(32'h2000_2000, 1);   // R3 ROM only
    // R7: size code below floor acts as 512 bytes
    wr(0, 32'h4000_0000, 3, 1);
    rd(32'h4000_01F0, 0);
    rd(32'h4000_0200, 0);
    // R7: size code 31 covers upper half; base bit 31 must match
    wr(1, 32'h8000_0000, 31, 1);
    rd(32'hFFFF_0000, 0);
    rd(32'h7FFF_0000, 0);
    // R8: disable SRAM window, address inside old range
    wr(0, 32'h4000_0000, 12, 0);
    rd(32'h4000_0010, 1);
    // R10: write and read same cycle; read sees old (disabled) SRAM
    step(1, 0, 32'h4000_0000, 12, 1, 1, 32'h4000_0010, 1, 32'h11, 32'h22, 32'h33);
    rd(32'h4000_0010, 1);
    // R10: move ROM while reading the new range
    step(1, 1, 32'h6000_0000, 10, 1, 1, 32'h6000_0004, 0, 32'h1, 32'h2, 32'h3);
    rd(32'h6000_0004, 0);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] a;
      int pick = $urandom_range(0, 4);
      case (pick)
        0: a = m_base[0] + ($urandom & 32'h0000_0FFF);
        1: a = m_base[1] + ($urandom & 32'h0000_FFFF);
        2: a = m_base[0] ^ (32'h1 << $urandom_range(8, 31));
        default: a = $urandom;
      endcase
      if ($urandom_range(0, 40) == 0)
        step(1, 1'($urandom), $urandom & 32'hFFFF_F000, $urandom_range(0, 31),
             ($urandom_range(0, 3) != 0), 1'($urandom), a, 1'($urandom),
             $urandom, $urandom, $urandom);
      else
        step(0, 0, 0, 0, 0, ($urandom_range(0, 5) != 0), a, 1'($urandom),
             $urandom, $urandom, $urandom);
    end
    done = 1;
    summary();
    $finish;
  end
endmodule